// File: doc/BRIEF.md
# JTAG Scan-Chain Enumerator

This block is a test-port master that a host-side controller starts with a single-cycle `go` pulse. It drives the scan clock, mode select and serial data lines of a boundary-scan chain and samples the serial return line. From this it finds out how many devices are on the chain and then reads every device's 32-bit identification word. The scan clock comes from the system clock through a programmable divider. The scan clock idles low whenever the block is not running.

To count the devices, the block first resets every test port and fills all instruction registers with a long run of ones, so that every device selects its one-bit bypass path. It then pushes zeros through the data path until the chain is clean. After that it shifts ones and counts scan clocks until the first one comes back. If no one comes back within a set limit, the chain is reported as broken. Otherwise every port is reset again, which selects the identification register. The block then streams out one word per device, each with a one-cycle strobe. The word from the device closest to the return line comes first. The block finishes by parking the chain in Run-Test/Idle and raising `done` for one system clock.

Top module: `jtag_enum_master`

## Requirements
- R1: While reset is held and afterwards until `go`, `tck`=0, `tms`=1, `tdi`=0, `busy`=0, `done`=0, `id_valid`=0, `dev_count`=0 and `count_err`=0.
- R2: The scan clock spends DIV_HALF system clocks in each phase and stays low when idle. `tms` and `tdi` change only in the cycle where `tck` falls, or at the start, never while `tck` is high. `tdo` is sampled in the cycle where `tck` rises.
- R3: A run starts with five clocks at `tms`=1. It then moves to Shift-IR with `tms` 0,1,1,0,0 and shifts IR_FILL ones, the last with `tms`=1. It then enters Shift-DR with `tms` 1,1,0,0 and shifts FLUSH_LEN zeros, so every device is flushed in bypass.
- R4: The block then shifts ones with `tms`=0. `dev_count` is the number of scan clocks before the one on which `tdo` first reads 1, which equals the number of devices.
- R5: If `tdo` stays 0 for COUNT_LIMIT count clocks, the block reports `dev_count`=0 and `count_err`=1 and reads no words. COUNT_LIMIT-1 devices is the largest count it can report.
- R6: After a good count, five `tms`-high clocks and `tms` 0,1,0,0 lead to Shift-DR. The block then shifts `dev_count`×ID_W bits, the last with `tms`=1. Each ID_W-bit word is assembled least-significant bit first and shown on `id_word` with a one-cycle `id_valid`. The first word belongs to the device next to `tdo`.
- R7: The run ends with the chain in Run-Test/Idle and `tck` low. At that point `done` pulses for exactly one system clock while `busy` drops. The total run length is 2·DIV_HALF system clocks per scan bit.
- R8: A `go` that arrives while `busy` is high is ignored and does not restart or lengthen the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start pulse, honoured only when idle |
| tdo | input | 1 | Serial data returned by the chain |
| tck | output | 1 | Divided scan clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data into the chain |
| busy | output | 1 | A run is in progress |
| dev_count | output | DEV_W | Number of devices found |
| count_err | output | 1 | No one came back within the count limit |
| id_word | output | ID_W | Most recently assembled identification word |
| id_valid | output | 1 | One-cycle strobe for `id_word` |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
On every cycle, the assertions check that the pins never change while the scan clock is high and that the clock is low whenever the block is idle. They also check that `done` is a single-cycle pulse coinciding with idle, that an error always comes with a zero count, and that word strobes occur only during a run. Only the bench scenarios can show the rest, because they need a behavioural model of a chain of test ports with bypass and identification registers. These results are the device count, the order and bit order of the streamed words, the error path with a stuck return line, the maximum countable chain, the final Run-Test/Idle state, the exact run length, and the ignored mid-run start.

// File: rtl/jenum_pkg.sv
// Shared types for the scan-chain enumerator.
// Assumes: none; types only.
package jenum_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_A,
        ST_TO_IR,
        ST_IR_FILL,
        ST_TO_DR_A,
        ST_FLUSH,
        ST_COUNT,
        ST_RST_B,
        ST_TO_DR_B,
        ST_READ,
        ST_EXIT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pin_pair_t;

endpackage

// File: rtl/jenum_tck_gen.sv
// Scan clock divider: toggles tck every DIV_HALF system clocks while run is
// high and emits single-cycle rise/fall strobes in the cycle whose closing
// edge changes tck. Assumes run is dropped only at a falling strobe.
module jenum_tck_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int DIV_W = $clog2(DIV_HALF) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             toggle;

    // Toggle request at the end of each half period.
    always_comb begin
        toggle = run && (div_cnt == DIV_LAST);
        rise   = toggle && !tck;
        fall   = toggle && tck;
    end

    // Half-period counter and clock register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            tck     <= 1'b0;
        end else if (toggle) begin
            div_cnt <= '0;
            tck     <= !tck;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tck);

    a_r2_edge_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/jenum_id_shift.sv
// Identification word assembler: shifts scan bits in least-significant bit
// first and raises valid for one cycle once the last bit of a word is in.
// Assumes the controller flags the last bit of each word.
module jenum_id_shift #(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    input  logic            last_bit,
    output logic [ID_W-1:0] word,
    output logic            valid
);
    // Shift register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= shift_en && last_bit;
            if (shift_en) begin
                word <= {bit_in, word[ID_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/jtag_enum_master.sv
// Scan-chain enumerator: resets the chain, forces bypass, flushes, counts
// devices by timing a returning one, then reads one identification word per
// device and parks the chain in Run-Test/Idle.
// Assumes every device loads its identification register on port reset and
// selects bypass when its instruction register holds all ones.
module jtag_enum_master
    import jenum_pkg::*;
#(
    parameter int DIV_HALF    = 4,
    parameter int IR_FILL     = 1000,
    parameter int FLUSH_LEN   = 1000,
    parameter int COUNT_LIMIT = 1000,
    parameter int ID_W        = 32,
    localparam int DEV_W      = $clog2(COUNT_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic [DEV_W-1:0] dev_count,
    output logic             count_err,
    output logic [ID_W-1:0]  id_word,
    output logic             id_valid,
    output logic             done
);
    localparam int MAX_A  = (IR_FILL > FLUSH_LEN) ? IR_FILL : FLUSH_LEN;
    localparam int MAX_L  = (MAX_A > COUNT_LIMIT) ? MAX_A : COUNT_LIMIT;
    localparam int CNT_W  = $clog2(MAX_L) + 1;
    localparam int BIT_W  = $clog2(ID_W);
    localparam logic [CNT_W-1:0] IR_LAST    = CNT_W'(IR_FILL - 1);
    localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(COUNT_LIMIT - 1);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(ID_W - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [DEV_W-1:0] word_idx;
    logic [BIT_W-1:0] bit_idx;
    logic             tck_rise, tck_fall;
    logic             word_last, read_last, shift_en;
    pin_pair_t        pins;

    jenum_tck_gen #(.DIV_HALF(DIV_HALF)) u_tck (
        .clk (clk), .rst_n (rst_n), .run (busy),
        .tck (tck), .rise (tck_rise), .fall (tck_fall)
    );

    // Position of the current bit within the identification read.
    always_comb begin
        word_last = (bit_idx == BIT_LAST);
        read_last = word_last && (word_idx == dev_count - DEV_W'(1));
        shift_en  = tck_rise && (state == ST_READ);
    end

    jenum_id_shift #(.ID_W(ID_W)) u_word (
        .clk (clk), .rst_n (rst_n), .shift_en (shift_en), .bit_in (tdo),
        .last_bit (word_last), .word (id_word), .valid (id_valid)
    );

    // Pin levels for the scan bit that the present state describes.
    always_comb begin
        pins = '{tms: 1'b0, tdi: 1'b0};
        unique case (state)
            ST_RST_A, ST_RST_B: pins.tms = 1'b1;
            ST_TO_IR:   pins.tms = (cnt == CNT_W'(1)) || (cnt == CNT_W'(2));
            ST_IR_FILL: pins = '{tms: (cnt == IR_LAST), tdi: 1'b1};
            ST_TO_DR_A: pins.tms = (cnt < CNT_W'(2));
            ST_COUNT:   pins.tdi = 1'b1;
            ST_TO_DR_B: pins.tms = (cnt == CNT_W'(1));
            ST_READ:    pins.tms = read_last;
            ST_EXIT:    pins.tms = (cnt != CNT_W'(2));
            default:    pins = '{tms: 1'b0, tdi: 1'b0};
        endcase
    end

    // Sequencer: start, advance on rising scan edges, drive pins on falling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            word_idx  <= '0;
            bit_idx   <= '0;
            busy      <= 1'b0;
            tms       <= 1'b1;
            tdi       <= 1'b0;
            dev_count <= '0;
            count_err <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (go) begin
                    state     <= ST_RST_A;
                    cnt       <= '0;
                    busy      <= 1'b1;
                    tms       <= 1'b1;
                    tdi       <= 1'b0;
                    dev_count <= '0;
                    count_err <= 1'b0;
                end
            end else if (tck_rise) begin
                cnt <= cnt + 1'b1;
                unique case (state)
                    ST_RST_A:   if (cnt == CNT_W'(4)) begin state <= ST_TO_IR;   cnt <= '0; end
                    ST_TO_IR:   if (cnt == CNT_W'(4)) begin state <= ST_IR_FILL; cnt <= '0; end
                    ST_IR_FILL: if (cnt == IR_LAST)   begin state <= ST_TO_DR_A; cnt <= '0; end
                    ST_TO_DR_A: if (cnt == CNT_W'(3)) begin state <= ST_FLUSH;   cnt <= '0; end
                    ST_FLUSH:   if (cnt == FLUSH_LAST) begin state <= ST_COUNT;  cnt <= '0; end
                    ST_COUNT: begin
                        if (tdo) begin
                            dev_count <= DEV_W'(cnt);
                            state     <= (cnt == '0) ? ST_EXIT : ST_RST_B;
                            cnt       <= '0;
                        end else if (cnt == CNT_LAST) begin
                            count_err <= 1'b1;
                            state     <= ST_EXIT;
                            cnt       <= '0;
                        end
                    end
                    ST_RST_B:   if (cnt == CNT_W'(4)) begin state <= ST_TO_DR_B; cnt <= '0; end
                    ST_TO_DR_B: if (cnt == CNT_W'(3)) begin
                        state    <= ST_READ;
                        word_idx <= '0;
                        bit_idx  <= '0;
                    end
                    ST_READ: begin
                        bit_idx <= bit_idx + 1'b1;
                        if (read_last) begin
                            state <= ST_EXIT;
                            cnt   <= CNT_W'(1);
                        end else if (word_last) begin
                            bit_idx  <= '0;
                            word_idx <= word_idx + 1'b1;
                        end
                    end
                    ST_EXIT:    if (cnt == CNT_W'(2)) state <= ST_FINISH;
                    default:    cnt <= cnt;
                endcase
            end else if (tck_fall) begin
                if (state == ST_FINISH) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end else begin
                    tms <= pins.tms;
                    tdi <= pins.tdi;
                end
            end
        end
    end

    a_r2_pins_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tms) && $stable(tdi)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !tck && !tms));

    a_r5_err_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        count_err |-> (dev_count == '0));

    a_r6_words_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> busy);

endmodule

// File: tb/jtag_enum_master_test.sv
// Scoreboard bench with a behavioural chain of test ports (4-bit IR each,
// all-ones selects bypass, reset selects the identification register).
module jtag_enum_master_test;
    localparam int DH = 2, IRF = 40, FL = 16, LIM = 8, IDW = 32, MAXD = 8;
    localparam int DEV_W = $clog2(LIM + 1);
    localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                   PADR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                   SHIR = 11, EX1IR = 12, PAIR = 13, EX2IR = 14, UPIR = 15;

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, tdo;
    logic tck, tms, tdi, busy, count_err, id_valid, done;
    logic [DEV_W-1:0] dev_count;
    logic [IDW-1:0]   id_word;

    int checks = 0, fails = 0, done_cnt = 0, viol = 0;
    logic [IDW-1:0] exp_q[$];

    // chain model
    int nd = 1, tap = TLR;
    bit stuck = 1'b0;
    logic [3:0]  ir[MAXD], ir_sr[MAXD];
    logic        bp[MAXD];
    logic [31:0] id_sr[MAXD], idc[MAXD];
    logic        tdo_m = 1'b0;

    always #5 clk = !clk;

    jtag_enum_master #(.DIV_HALF(DH), .IR_FILL(IRF), .FLUSH_LEN(FL),
                       .COUNT_LIMIT(LIM), .ID_W(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .tdo(tdo), .tck(tck), .tms(tms),
        .tdi(tdi), .busy(busy), .dev_count(dev_count), .count_err(count_err),
        .id_word(id_word), .id_valid(id_valid), .done(done));

    assign tdo = stuck ? 1'b0 : tdo_m;

    function automatic int tap_next(int s, logic m);
        case (s)
            TLR:   return m ? TLR   : RTI;
            RTI:   return m ? SELDR : RTI;
            SELDR: return m ? SELIR : CAPDR;
            CAPDR: return m ? EX1DR : SHDR;
            SHDR:  return m ? EX1DR : SHDR;
            EX1DR: return m ? UPDR  : PADR;
            PADR:  return m ? EX2DR : PADR;
            EX2DR: return m ? UPDR  : SHDR;
            UPDR:  return m ? SELDR : RTI;
            SELIR: return m ? TLR   : CAPIR;
            CAPIR: return m ? EX1IR : SHIR;
            SHIR:  return m ? EX1IR : SHIR;
            EX1IR: return m ? UPIR  : PAIR;
            PAIR:  return m ? EX2IR : PAIR;
            EX2IR: return m ? UPIR  : SHIR;
            default: return m ? SELDR : RTI;
        endcase
    endfunction

    // Chain: capture/shift/update on rising scan edge.
    always @(posedge tck) begin
        int nx;
        for (int d = nd - 1; d >= 0; d--) begin
            logic din;
            if (tap == SHIR) begin
                din = (d == 0) ? tdi : ir_sr[d-1][0];
                ir_sr[d] = {din, ir_sr[d][3:1]};
            end else if (tap == SHDR) begin
                din = (d == 0) ? tdi : ((ir[d-1] == 4'hF) ? bp[d-1] : id_sr[d-1][0]);
                if (ir[d] == 4'hF) bp[d] = din;
                else id_sr[d] = {din, id_sr[d][31:1]};
            end else if (tap == CAPIR) ir_sr[d] = 4'b0001;
            else if (tap == CAPDR) begin bp[d] = 1'b0; id_sr[d] = idc[d]; end
            else if (tap == UPIR) ir[d] = ir_sr[d];
        end
        nx = tap_next(tap, tms);
        if (nx == TLR) for (int d = 0; d < MAXD; d++) ir[d] = 4'h2;
        tap = nx;
    end

    // Chain: serial output changes on falling scan edge.
    always @(negedge tck) begin
        if (tap == SHIR) tdo_m = ir_sr[nd-1][0];
        else if (tap == SHDR) tdo_m = (ir[nd-1] == 4'hF) ? bp[nd-1] : id_sr[nd-1][0];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: word scoreboard, done pulses and pin steadiness (R2, R6, R7).
    logic ptms = 1'b1, ptdi = 1'b0, pdone = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tck && (tms !== ptms || tdi !== ptdi)) viol++;
            if (done) done_cnt++;
            if (done && pdone) begin
                fails++; checks++;
                $display("FAIL R7 done wider than one clock actual=2 expected=1");
            end
            if (id_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected word actual=%h expected=none", id_word);
                end else begin
                    logic [IDW-1:0] e;
                    e = exp_q.pop_front();
                    if (id_word !== e) begin
                        fails++;
                        $display("FAIL R6 id word actual=%h expected=%h", id_word, e);
                    end
                end
            end
        end
        ptms = tms; ptdi = tdi; pdone = done;
    end

    // Driver: set up a chain, queue expected words, run, check results.
    task automatic run_case(input int n, input bit stk, input bit regos);
        int cyc = 0, bits;
        nd = n; stuck = stk; done_cnt = 0; tap = TLR; tdo_m = 1'b0;
        for (int d = 0; d < MAXD; d++) begin
            ir[d] = 4'h2; ir_sr[d] = 4'h0; bp[d] = 1'b0; id_sr[d] = '0;
            idc[d] = 32'h0A50_0001 + 32'h0101_2202 * d;
            idc[d][0] = 1'b1;
        end
        if (!stk) for (int d = n - 1; d >= 0; d--) exp_q.push_back(idc[d]);
        bits = stk ? (5 + 5 + IRF + 4 + FL + LIM + 3)
                   : (5 + 5 + IRF + 4 + FL + (n + 1) + 5 + 4 + IDW * n + 2);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        while (!done && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (regos && cyc == 300) go = 1'b1;
            if (regos && cyc == 301) go = 1'b0;
        end
        // R4/R5 count and error flag
        chk(dev_count == (stk ? 0 : n), "R4", "device count", dev_count, stk ? 0 : n);
        chk(count_err == stk, "R5", "count_err", count_err, stk);
        // R6 all words received
        chk(exp_q.size() == 0, "R6", "words outstanding", exp_q.size(), 0);
        // R7 / R8 run length exactly 2*DH per scan bit
        chk(cyc == 2 * DH * bits, regos ? "R8" : "R7", "run length", cyc, 2 * DH * bits);
        // R7 chain parked in Run-Test/Idle, clock low
        chk(tap == RTI && !tck, "R7", "final tap state", tap, RTI);
        chk(!busy, "R7", "busy at done", busy, 0);
        repeat (2 * DH * 4) @(negedge clk);
        chk(done_cnt == 1 && !busy, "R7", "done pulses", done_cnt, 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk({tck, tms, tdi, busy, done, id_valid, count_err} == 7'b0100000,
            "R1", "pins during reset", {tck, tms, tdi, busy, done, id_valid, count_err}, 7'b0100000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!tck && tms && !busy && dev_count == 0, "R1", "idle after reset",
            {tck, tms, busy}, 3'b010);
        run_case(1, 1'b0, 1'b0);   // R3 R4 R6 single device
        run_case(3, 1'b0, 1'b1);   // R8 go ignored mid-run
        run_case(LIM - 1, 1'b0, 1'b0); // R5 largest countable chain
        run_case(2, 1'b1, 1'b0);   // R5 stuck return line
        run_case(2, 1'b0, 1'b0);   // R5 error cleared by next run
        chk(viol == 0, "R2", "pin changes while tck high", viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule